// File: doc/BRIEF.md
# Dual-Channel Converter Serial Write Sequencer

This block sits on the host side of a two-channel serial-input converter and turns one request into the complete pin sequence the converter needs. A request carries two 16-bit codes and a mode bit. In split mode the block writes channel A, then channel B, with the load strobe held high, and then pulses load low once so that both outputs change together. In shared mode it sends a single frame addressed to both channels, carrying the channel A code, and leaves the load strobe alone.

Every frame is 18 bits long and is shifted out most significant bit first: a 2-bit channel address followed by the 16-bit code. The block drives an active-low chip select, a serial clock that idles low, serial data that changes on the falling clock edge, and an active-low load strobe. Parameters give the serial clock half period and the setup, hold, gap and strobe widths in system clock cycles, so the host picks values that meet the converter's timing at its own clock rate. A one-cycle done pulse marks the end of each sequence. A new request is taken only while the block is idle.

Top module: `dac_seq_ctrl`

## Requirements
- R1: After reset, and at once while rst_ni is low, cs_no=1, sclk_o=0, ldac_no=1, sdi_o=0, done_o=0 and busy_o=0.
- R2: Each frame carries 18 bits, sampled on the rising edges of sclk_o and sent most significant bit first: bits 17:16 hold the channel address and bits 15:0 the code.
- R3: cs_no is low across exactly 18 rising sclk_o edges; the first rising edge comes SETUP_CYC cycles after cs_no falls, and cs_no rises HALF_CYC+HOLD_CYC cycles after the last rising edge.
- R4: sclk_o stays low and does not toggle while cs_no is high.
- R5: Within a frame every high and every low phase of sclk_o between toggles lasts HALF_CYC cycles.
- R6: With common_i=0, the first frame has address 01 and code_a_i and the second has address 10 and code_b_i; cs_no stays high for GAP_CYC+2 cycles between them, and ldac_no is high whenever cs_no is low.
- R7: With common_i=0, ldac_no goes low exactly once, LD_SU_CYC+1 cycles after cs_no rises at the end of the second frame, and stays low for LD_W_CYC cycles.
- R8: With common_i=1, exactly one frame is sent, with address 11 and code_a_i; code_b_i has no effect and ldac_no stays high.
- R9: done_o is high for exactly one cycle per request: in the cycle ldac_no returns high for common_i=0, or one cycle after cs_no rises for common_i=1.
- R10: busy_o is high from the cycle after an accepted start_i until done_o; start_i while busy_o is high has no effect on the frames sent and is not queued.
- R11: sdi_o does not change in the cycle where sclk_o rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only while idle |
| common_i | input | 1 | 1: one shared frame to both channels; 0: split write with load strobe |
| code_a_i | input | 16 | Code for channel A, also the shared code |
| code_b_i | input | 16 | Code for channel B |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdi_o | output | 1 | Serial data, MSB first |
| ldac_no | output | 1 | Load strobe, active low |

## Verification
The assertions assume every timing parameter is at least one cycle and that the request fields are read only in the cycle start_i is taken while idle. Past that point they assume nothing about when start_i arrives, so the bench raises start_i in the middle of a frame to show that such a request changes neither the latched codes nor the pins. The bench drives each start_i pulse for one cycle, between clock edges, and decodes the frames, gaps and strobe timing from the pins alone.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int ADDR_W  = 2;
  localparam int CODE_W  = 16;
  localparam int FRAME_W = ADDR_W + CODE_W;

  localparam logic [ADDR_W-1:0] ADDR_CH_A = 2'b01;
  localparam logic [ADDR_W-1:0] ADDR_CH_B = 2'b10;
  localparam logic [ADDR_W-1:0] ADDR_BOTH = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FRM1, SQ_GAP, SQ_FRM2, SQ_LD_SU, SQ_LD_LOW
  } seq_state_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_SETUP, FR_HIGH, FR_LOW, FR_HOLD
  } frm_state_e;
endpackage

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             fire_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  // fire_o is high in the cycle after len_i edges have passed since start_i
  assign fire_o = run_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= len_i;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (fire_o) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_seq_frame.sv
module dac_seq_frame
  import dac_seq_pkg::*;
#(
  parameter int HALF_CYC  = 2,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic               sdi_o,
  output logic               done_o
);
  localparam int MAX_A   = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
  localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  frm_state_e         st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] shr_q;
  logic               cs_n_q, sclk_q, done_q;

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;
  assign sdi_o  = shr_q[FRAME_W-1];
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      shr_q  <= '0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        FR_IDLE: begin
          if (start_i) begin
            shr_q  <= word_i;
            cs_n_q <= 1'b0;
            bit_q  <= '0;
            cnt_q  <= SETUP_LD;
            st_q   <= FR_SETUP;
          end
        end
        FR_SETUP: begin
          if (cnt_q == '0) begin
            sclk_q <= 1'b1;
            cnt_q  <= HALF_LD;
            st_q   <= FR_HIGH;
          end else cnt_q <= cnt_q - 1'b1;
        end
        FR_HIGH: begin
          if (cnt_q == '0) begin
            sclk_q <= 1'b0;
            if (bit_q == LAST_BIT) begin
              cnt_q <= HOLD_LD;
              st_q  <= FR_HOLD;
            end else begin
              // next bit appears on the falling edge
              shr_q <= {shr_q[FRAME_W-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
              cnt_q <= HALF_LD;
              st_q  <= FR_LOW;
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        FR_LOW: begin
          if (cnt_q == '0) begin
            sclk_q <= 1'b1;
            cnt_q  <= HALF_LD;
            st_q   <= FR_HIGH;
          end else cnt_q <= cnt_q - 1'b1;
        end
        FR_HOLD: begin
          if (cnt_q == '0) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
            st_q   <= FR_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  // checker state: rising sclk edges seen in the current frame
  logic             sclk_d_q;
  logic [BIT_W:0]   edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      edges_q  <= '0;
    end else begin
      sclk_d_q <= sclk_q;
      if (cs_n_q && !(st_q == FR_IDLE && start_i)) edges_q <= edges_q;
      if (!cs_n_q && sclk_q && !sclk_d_q) edges_q <= edges_q + 1'b1;
      else if (st_q == FR_IDLE && start_i) edges_q <= '0;
    end
  end

  p_sclk_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sclk_q);
  p_frame_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_q) |-> (edges_q == (BIT_W+1)'(FRAME_W)));
  p_sdi_setup_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> $stable(shr_q[FRAME_W-1]));
  p_done_at_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $rose(cs_n_q));
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int HALF_CYC  = 2,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int GAP_CYC   = 2,
  parameter int LD_SU_CYC = 1,
  parameter int LD_W_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              common_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              ldac_no
);
  localparam int MAX_A = (GAP_CYC > LD_SU_CYC) ? GAP_CYC : LD_SU_CYC;
  localparam int MAX_T = (MAX_A > LD_W_CYC) ? MAX_A : LD_W_CYC;
  localparam int TMR_W = $clog2(MAX_T + 1);

  seq_state_e         st_q;
  logic               common_q;
  logic [CODE_W-1:0]  code_a_q, code_b_q;
  logic               frm_start_q;
  logic [FRAME_W-1:0] frm_word_q;
  logic               ldac_n_q, done_q;
  logic               frm_done, frm_cs_n;
  logic               tmr_start, tmr_fire;
  logic [TMR_W-1:0]   tmr_len;

  dac_seq_frame #(
    .HALF_CYC (HALF_CYC),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(frm_start_q),
    .word_i (frm_word_q),
    .cs_n_o (frm_cs_n),
    .sclk_o (sclk_o),
    .sdi_o  (sdi_o),
    .done_o (frm_done)
  );

  dac_seq_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .len_i  (tmr_len),
    .fire_o (tmr_fire)
  );

  always_comb begin
    tmr_start = 1'b0;
    tmr_len   = TMR_W'(LD_W_CYC);
    unique case (st_q)
      SQ_FRM1: begin
        tmr_start = frm_done && !common_q;
        tmr_len   = TMR_W'(GAP_CYC);
      end
      SQ_FRM2: begin
        tmr_start = frm_done;
        tmr_len   = TMR_W'(LD_SU_CYC);
      end
      SQ_LD_SU: tmr_start = tmr_fire;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_IDLE;
      common_q    <= 1'b0;
      code_a_q    <= '0;
      code_b_q    <= '0;
      frm_start_q <= 1'b0;
      frm_word_q  <= '0;
      ldac_n_q    <= 1'b1;
      done_q      <= 1'b0;
    end else begin
      frm_start_q <= 1'b0;
      done_q      <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            common_q    <= common_i;
            code_a_q    <= code_a_i;
            code_b_q    <= code_b_i;
            frm_word_q  <= {common_i ? ADDR_BOTH : ADDR_CH_A, code_a_i};
            frm_start_q <= 1'b1;
            st_q        <= SQ_FRM1;
          end
        end
        SQ_FRM1: begin
          if (frm_done) begin
            if (common_q) begin
              done_q <= 1'b1;
              st_q   <= SQ_IDLE;
            end else st_q <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          if (tmr_fire) begin
            frm_word_q  <= {ADDR_CH_B, code_b_q};
            frm_start_q <= 1'b1;
            st_q        <= SQ_FRM2;
          end
        end
        SQ_FRM2: if (frm_done) st_q <= SQ_LD_SU;
        SQ_LD_SU: begin
          if (tmr_fire) begin
            ldac_n_q <= 1'b0;
            st_q     <= SQ_LD_LOW;
          end
        end
        SQ_LD_LOW: begin
          if (tmr_fire) begin
            ldac_n_q <= 1'b1;
            done_q   <= 1'b1;
            st_q     <= SQ_IDLE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign done_o  = done_q;
  assign cs_no   = frm_cs_n;
  assign ldac_no = ldac_n_q;

  p_ldac_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> ldac_no);
  p_no_strobe_shared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && common_q) |-> ldac_no);
  p_strobe_after_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ldac_no) |-> (cs_no && st_q == SQ_LD_LOW));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(code_a_q) && $stable(code_b_q) && $stable(common_q)));
endmodule

// File: tb/dac_seq_ctrl_tb.sv
module dac_seq_ctrl_tb;
  localparam int HALF_CYC  = 2;
  localparam int SETUP_CYC = 2;
  localparam int HOLD_CYC  = 2;
  localparam int GAP_CYC   = 2;
  localparam int LD_SU_CYC = 1;
  localparam int LD_W_CYC  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, common_i = 1'b0;
  logic [15:0] code_a_i = '0, code_b_i = '0;
  logic busy_o, done_o, cs_no, sclk_o, sdi_o, ldac_no;

  always #4 clk = ~clk;

  dac_seq_ctrl #(
    .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .GAP_CYC(GAP_CYC), .LD_SU_CYC(LD_SU_CYC), .LD_W_CYC(LD_W_CYC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .common_i(common_i),
    .code_a_i(code_a_i), .code_b_i(code_b_i), .busy_o(busy_o), .done_o(done_o),
    .cs_no(cs_no), .sclk_o(sclk_o), .sdi_o(sdi_o), .ldac_no(ldac_no)
  );

  // {common, code_a, code_b}
  localparam int NVEC = 6;
  localparam logic [32:0] VEC [0:NVEC-1] = '{
    {1'b0, 16'h1234, 16'hABCD},
    {1'b1, 16'h8000, 16'h5555},
    {1'b0, 16'hFFFF, 16'h0000},
    {1'b0, 16'h0000, 16'hFFFF},
    {1'b1, 16'h0001, 16'hFFFF},
    {1'b0, 16'hA5A5, 16'h5A5A}
  };

  int nchk = 0, nerr = 0;

  // pin monitor, sampled between edges
  logic mon_clr = 1'b0;
  int cyc = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_ld = 1'b1, p_done = 1'b0;
  logic [17:0] sh = '0;
  logic [17:0] fw [0:3];
  int fbits [0:3], cs_fall [0:3], cs_rise [0:3], f_first [0:3], f_last [0:3];
  int nbits = 0, cur_first = 0, cur_last = 0, nfr = 0, n_ld = 0;
  int ld_fall = 0, ld_rise = 0, n_done = 0, done_c = 0, done_wide = 0;
  int phase_err = 0, quiet_err = 0, last_tog = 0;
  bit seen_tog = 0;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      nfr = 0; n_ld = 0; n_done = 0; done_wide = 0;
      phase_err = 0; quiet_err = 0; nbits = 0; seen_tog = 0;
    end else begin
      if (p_cs && !cs_no) begin
        if (nfr < 4) cs_fall[nfr] = cyc;
        nbits = 0; sh = '0; seen_tog = 0;
      end
      if (sclk_o != p_sclk) begin
        if (cs_no && p_cs) quiet_err++;
        else if (!cs_no) begin
          if (seen_tog && (cyc - last_tog != HALF_CYC)) phase_err++;
          seen_tog = 1; last_tog = cyc;
        end
      end
      if (!p_sclk && sclk_o && !cs_no) begin
        sh = {sh[16:0], sdi_o};
        nbits++;
        if (nbits == 1) cur_first = cyc;
        cur_last = cyc;
      end
      if (!p_cs && cs_no && nfr < 4) begin
        fw[nfr] = sh; fbits[nfr] = nbits; cs_rise[nfr] = cyc;
        f_first[nfr] = cur_first; f_last[nfr] = cur_last;
        nfr++;
      end
      if (p_ld && !ldac_no) begin n_ld++; ld_fall = cyc; end
      if (!p_ld && ldac_no) ld_rise = cyc;
      if (!ldac_no && !cs_no) quiet_err++;
      if (done_o) begin
        n_done++; done_c = cyc;
        if (p_done) done_wide++;
      end
    end
    p_sclk = sclk_o; p_cs = cs_no; p_ld = ldac_no; p_done = done_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clr_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic pulse_start(input logic cm, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    start_i = 1'b1; common_i = cm; code_a_i = a; code_b_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (n_done > 0) break;
      @(negedge clk);
    end
    if (n_done == 0) chk("R9 watchdog: done never seen", 0, 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_seq(input logic cm, input logic [15:0] a, input logic [15:0] b);
    chk("R6/R8 frame count", nfr, cm ? 1 : 2);
    chk("R2 first frame word", int'(fw[0]), int'({cm ? 2'b11 : 2'b01, a}));
    chk("R3 first frame bits", fbits[0], 18);
    chk("R3 cs fall to first sclk rise", f_first[0] - cs_fall[0], SETUP_CYC);
    chk("R3 last sclk rise to cs rise", cs_rise[0] - f_last[0], HALF_CYC + HOLD_CYC);
    chk("R5 sclk phase errors", phase_err, 0);
    chk("R4 sclk toggles with cs high / R6 strobe during frame", quiet_err, 0);
    chk("R9 done pulses", n_done, 1);
    chk("R9 done wider than one cycle", done_wide, 0);
    chk("R10 busy after done", int'(busy_o), 0);
    if (cm) begin
      chk("R8 strobe count in shared mode", n_ld, 0);
      chk("R9 done timing shared", done_c - cs_rise[0], 1);
    end else begin
      chk("R6 second frame word", int'(fw[1]), int'({2'b10, b}));
      chk("R3 second frame bits", fbits[1], 18);
      chk("R6 gap between frames", cs_fall[1] - cs_rise[0], GAP_CYC + 2);
      chk("R7 strobe count", n_ld, 1);
      chk("R7 strobe setup", ld_fall - cs_rise[1], LD_SU_CYC + 1);
      chk("R7 strobe width", ld_rise - ld_fall, LD_W_CYC);
      chk("R9 done with strobe release", done_c, ld_rise);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nerr + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state while rst_ni is low
    chk("R1 cs_no in reset", int'(cs_no), 1);
    chk("R1 sclk_o in reset", int'(sclk_o), 0);
    chk("R1 ldac_no in reset", int'(ldac_no), 1);
    chk("R1 sdi_o in reset", int'(sdi_o), 0);
    chk("R1 done_o in reset", int'(done_o), 0);
    chk("R1 busy_o in reset", int'(busy_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", int'(cs_no & ~sclk_o & ldac_no & ~busy_o), 1);

    for (int v = 0; v < NVEC; v++) begin
      clr_mon();
      pulse_start(VEC[v][32], VEC[v][31:16], VEC[v][15:0]);
      chk("R10 busy after accepted start", int'(busy_o), 1);
      wait_done();
      check_seq(VEC[v][32], VEC[v][31:16], VEC[v][15:0]);
    end

    // R10: start while busy is ignored and not queued
    clr_mon();
    pulse_start(1'b0, 16'h1111, 16'h2222);
    repeat (20) @(negedge clk);
    pulse_start(1'b1, 16'hEEEE, 16'hDDDD);
    wait_done();
    check_seq(1'b0, 16'h1111, 16'h2222);
    repeat (200) @(negedge clk);
    chk("R10 no queued request frames", nfr, 2);
    chk("R10 no queued request busy", int'(busy_o), 0);

    // R1: asynchronous reset in the middle of a frame
    clr_mon();
    pulse_start(1'b0, 16'h0F0F, 16'hF0F0);
    repeat (15) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 cs_no at mid-frame reset", int'(cs_no), 1);
    chk("R1 sclk_o at mid-frame reset", int'(sclk_o), 0);
    chk("R1 busy_o at mid-frame reset", int'(busy_o), 0);
    chk("R1 ldac_no at mid-frame reset", int'(ldac_no), 1);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // fresh request after the reset completes normally
    clr_mon();
    pulse_start(1'b0, 16'h7FFF, 16'h8001);
    wait_done();
    check_seq(1'b0, 16'h7FFF, 16'h8001);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule